// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers eight interrupt request lines for an 8-bit processor that reaches its peripherals through memory-mapped reads and writes. A falling edge on a request line sets a per-line pending latch. A mask register decides which pending latches may pull the shared active-low interrupt output low. A cascade input, active low, also pulls that output low so that several controllers can be chained. Priority is fixed: line 7 wins over every other line, and line 0 loses to every other line.

When the processor takes the interrupt, it fetches three consecutive bytes from the controller's chip space. The block answers with a complete long-branch instruction: the opcode, the high address byte from a page register, and a low byte. The low byte is assembled from the upper control-register bits and the index of the serviced request, with a vector spacing of 2, 4, 8 or 16 bytes. The first fetch byte also clears the latch of the serviced request. For software that polls instead of taking interrupts, the same low byte can be read through a polling register. A status register shows every pending latch, and reading it clears all of them.

Top module: `vic_ctrl`

## Requirements
- R1: After reset, irq_n_o is 1, rdata_oe_o is 0, page, control and mask hold 0, no latch is pending, and the fetch sequence starts at its first byte.
- R2: A request latch is set when its line is sampled 1 on one clock edge and 0 on the next edge. A line held low or rising sets nothing. A set latch stays set until it is cleared.
- R3: A read with addr_i=0 returns the status byte, where bit i is 1 if latch i is pending, masked or not. That read clears all latches, except a latch whose falling edge is captured in the same cycle.
- R4: A write with addr_i=2 loads the mask register. A 1 in bit i stops latch i from driving irq_n_o, but latch i is still set and still shows in the status byte.
- R5: irq_n_o is 0 exactly when some latch is pending with its mask bit at 0, or when cascade_n_i is 0. The cascade input ignores the mask.
- R6: Fetch cycles (cs_i=1, fetch_i=1) return, in turn, 8'hC0, then the page register (written at addr_i=0), then the low vector byte. The sequence then restarts with the opcode.
- R7: On the opcode fetch, the block selects the highest-numbered pending unmasked latch (line 7 highest) for the low vector byte, and clears only that latch.
- R8: Control register (written at addr_i=1) bits [1:0] select the spacing (00=2, 01=4, 10=8, 11=16 bytes) and give the shift s=1,2,3,4. The low vector byte is the control byte with bits below s+3 cleared, ORed with the 3-bit index shifted left by s. Control bits [3:2] are ignored.
- R9: A read with addr_i=1 returns the low vector byte for the highest-numbered pending latch, ignoring the mask (index 0 if none is pending). This read clears no latch.
- R10: rdata_oe_o is 1 only when cs_i=1 and either fetch_i=1 or rd_i=1 with addr_i of 0 or 1. Writes with cs_i=0, and writes to addr_i=3, change no register.
- R11: If no unmasked latch is pending at the opcode fetch, the low vector byte uses index 0 and no latch is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_i | input | 8 | Request lines, sampled; a falling edge sets the latch |
| cascade_n_i | input | 1 | Active-low interrupt from a chained controller |
| cs_i | input | 1 | Decoded chip select |
| addr_i | input | 2 | Register select within the chip space |
| rd_i | input | 1 | Register read strobe |
| wr_i | input | 1 | Register write strobe |
| fetch_i | input | 1 | Processor instruction-fetch strobe, one byte per cycle |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read and fetch data |
| rdata_oe_o | output | 1 | Data bus drive enable; 0 means released |
| irq_n_o | output | 1 | Active-low interrupt request |

## Verification
The bench builds the controller with its default parameters: eight request lines, an 8-bit bus and a 2-bit spacing select. With these values, all four vector spacings and all eight priority levels can be reached, and so can the case where the index fills the low byte up to bit 6. Directed sequences cover edge capture while a status read clears the latches, the masked-winner fetch and the fetch with nothing pending. A long random run of request toggles, mask changes, cascade changes and register accesses is then compared against the behavioural model in every cycle.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam logic [7:0] VIC_OP_LBR = 8'hC0;

  typedef enum logic [1:0] {
    PH_OP = 2'd0,
    PH_HI = 2'd1,
    PH_LO = 2'd2
  } vic_phase_e;

  typedef enum logic [1:0] {
    RA_PAGE = 2'd0,
    RA_CTRL = 2'd1,
    RA_MASK = 2'd2,
    RA_NONE = 2'd3
  } vic_wsel_e;

  localparam logic [1:0] RD_STATUS = 2'd0;
  localparam logic [1:0] RD_POLL   = 2'd1;
endpackage

// File: rtl/vic_req_latch.sv
module vic_req_latch #(
  parameter int unsigned N_REQ = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_REQ-1:0] req_i,
  input  logic [N_REQ-1:0] clr_i,
  output logic [N_REQ-1:0] set_o,
  output logic [N_REQ-1:0] lat_o
);
  logic [N_REQ-1:0] prev_q;
  logic [N_REQ-1:0] lat_q;
  logic [N_REQ-1:0] lat_d;
  logic [N_REQ-1:0] set_w;

  // a fresh edge outranks a clear in the same cycle
  always_comb begin
    set_w = prev_q & ~req_i;
    lat_d = (lat_q & ~clr_i) | set_w;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      lat_q  <= '0;
    end else begin
      prev_q <= req_i;
      lat_q  <= lat_d;
    end
  end

  assign set_o = set_w;
  assign lat_o = lat_q;

  for (genvar g = 0; g < N_REQ; g++) begin : g_chk
    p_edge_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (prev_q[g] && !req_i[g]) |=> lat_q[g]);
    p_latch_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (lat_q[g] && !clr_i[g]) |=> lat_q[g]);
  end
endmodule

// File: rtl/vic_prio.sv
module vic_prio #(
  parameter int unsigned N_REQ = 8,
  localparam int unsigned IW = $clog2(N_REQ)
) (
  input  logic [N_REQ-1:0] vec_i,
  output logic             any_o,
  output logic [IW-1:0]    idx_o
);
  // ascending scan: the highest set bit is the last to write
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = 0; i < N_REQ; i++) begin
      if (vec_i[i]) begin
        any_o = 1'b1;
        idx_o = IW'(i);
      end
    end
  end
endmodule

// File: rtl/vic_vector.sv
module vic_vector #(
  parameter int unsigned DW = 8,
  parameter int unsigned IW = 3,
  parameter int unsigned SW = 2,
  localparam int unsigned NSPC = 1 << SW
) (
  input  logic [DW-1:0] ctrl_i,
  input  logic [IW-1:0] idx_i,
  output logic [DW-1:0] low_o
);
  logic [DW-1:0] cand [NSPC];

  for (genvar g = 0; g < NSPC; g++) begin : g_spc
    localparam int unsigned SH = g + 1;
    localparam logic [DW-1:0] HI = ~((DW'(1) << (SH + IW)) - DW'(1));
    assign cand[g] = (ctrl_i & HI) | (DW'(idx_i) << SH);
  end

  assign low_o = cand[ctrl_i[SW-1:0]];
endmodule

// File: rtl/vic_ctrl.sv
module vic_ctrl
  import vic_pkg::*;
#(
  parameter int unsigned N_REQ = 8,
  parameter int unsigned DW    = 8,
  parameter int unsigned AW    = 2,
  parameter int unsigned SW    = 2,
  localparam int unsigned IW   = $clog2(N_REQ)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_REQ-1:0] req_i,
  input  logic             cascade_n_i,
  input  logic             cs_i,
  input  logic [AW-1:0]    addr_i,
  input  logic             rd_i,
  input  logic             wr_i,
  input  logic             fetch_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o,
  output logic             rdata_oe_o,
  output logic             irq_n_o
);
  // reset: asynchronous assert, synchronous release
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic [DW-1:0]    page_q, page_d, ctrl_q, ctrl_d;
  logic [N_REQ-1:0] mask_q, mask_d;
  vic_phase_e       phase_q, phase_d;
  logic [IW-1:0]    idx_q, idx_d;
  logic             page_en, ctrl_en, mask_en, phase_en, idx_en;

  logic [N_REQ-1:0] lat, set_vec, clr_vec, unm_vec;
  logic             any_unm, any_all;
  logic [IW-1:0]    idx_unm, idx_all;
  logic [DW-1:0]    low_poll, low_fetch;

  logic wr_hit, fetch_hit, status_rd, poll_rd;

  always_comb begin
    wr_hit    = cs_i & wr_i & ~fetch_i;
    fetch_hit = cs_i & fetch_i;
    status_rd = cs_i & rd_i & ~fetch_i & (addr_i == AW'(RD_STATUS));
    poll_rd   = cs_i & rd_i & ~fetch_i & (addr_i == AW'(RD_POLL));
    unm_vec   = lat & ~mask_q;
  end

  vic_req_latch #(.N_REQ(N_REQ)) u_latch (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .req_i (req_i),
    .clr_i (clr_vec),
    .set_o (set_vec),
    .lat_o (lat)
  );

  vic_prio #(.N_REQ(N_REQ)) u_prio_unm (
    .vec_i (unm_vec),
    .any_o (any_unm),
    .idx_o (idx_unm)
  );

  vic_prio #(.N_REQ(N_REQ)) u_prio_all (
    .vec_i (lat),
    .any_o (any_all),
    .idx_o (idx_all)
  );

  vic_vector #(.DW(DW), .IW(IW), .SW(SW)) u_vec_poll (
    .ctrl_i (ctrl_q),
    .idx_i  (idx_all),
    .low_o  (low_poll)
  );

  vic_vector #(.DW(DW), .IW(IW), .SW(SW)) u_vec_fetch (
    .ctrl_i (ctrl_q),
    .idx_i  (idx_q),
    .low_o  (low_fetch)
  );

  // next-state
  always_comb begin
    page_en  = wr_hit & (addr_i == AW'(RA_PAGE));
    ctrl_en  = wr_hit & (addr_i == AW'(RA_CTRL));
    mask_en  = wr_hit & (addr_i == AW'(RA_MASK));
    page_d   = wdata_i;
    ctrl_d   = wdata_i;
    mask_d   = wdata_i[N_REQ-1:0];

    phase_en = fetch_hit;
    unique case (phase_q)
      PH_OP:   phase_d = PH_HI;
      PH_HI:   phase_d = PH_LO;
      default: phase_d = PH_OP;
    endcase

    idx_en = fetch_hit & (phase_q == PH_OP);
    idx_d  = any_unm ? idx_unm : '0;

    clr_vec = '0;
    if (status_rd) clr_vec = '1;
    if (idx_en && any_unm) clr_vec[idx_unm] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      page_q  <= '0;
      ctrl_q  <= '0;
      mask_q  <= '0;
      phase_q <= PH_OP;
      idx_q   <= '0;
    end else begin
      if (page_en)  page_q  <= page_d;
      if (ctrl_en)  ctrl_q  <= ctrl_d;
      if (mask_en)  mask_q  <= mask_d;
      if (phase_en) phase_q <= phase_d;
      if (idx_en)   idx_q   <= idx_d;
    end
  end

  // bus read path
  always_comb begin
    rdata_oe_o = fetch_hit | status_rd | poll_rd;
    rdata_o    = '0;
    if (fetch_hit) begin
      unique case (phase_q)
        PH_OP:   rdata_o = DW'(VIC_OP_LBR);
        PH_HI:   rdata_o = page_q;
        default: rdata_o = low_fetch;
      endcase
    end else if (status_rd) begin
      rdata_o = DW'(lat);
    end else if (poll_rd) begin
      rdata_o = low_poll;
    end
  end

  assign irq_n_o = ~((|unm_vec) | ~cascade_n_i);

  p_opcode_first_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (fetch_hit && phase_q == PH_OP) |-> (rdata_oe_o && rdata_o == DW'(VIC_OP_LBR)));
  p_phase_step_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    fetch_hit |=> (phase_q != $past(phase_q)));
  p_winner_live_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    any_unm |-> (lat[idx_unm] && !mask_q[idx_unm]));
  p_status_wipe_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    status_rd |=> ((lat & ~$past(set_vec)) == '0));
  p_bus_quiet_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !cs_i |-> !rdata_oe_o);
  p_cascade_pull_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !cascade_n_i |-> !irq_n_o);
  p_poll_no_clear_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (poll_rd && !fetch_hit) |=> ((lat & $past(lat)) == $past(lat)));
endmodule

// File: tb/tb_vic_ctrl.sv
module tb_vic_ctrl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] req;
  logic       cascade_n, cs, rd, wr, fetch;
  logic [1:0] addr;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic       rdata_oe, irq_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  vic_ctrl dut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .cascade_n_i(cascade_n),
    .cs_i(cs), .addr_i(addr), .rd_i(rd), .wr_i(wr), .fetch_i(fetch),
    .wdata_i(wdata), .rdata_o(rdata), .rdata_oe_o(rdata_oe), .irq_n_o(irq_n)
  );

  // behavioural reference
  logic [7:0] m_lat, m_prev, m_page, m_ctrl, m_mask;
  int         m_phase, m_idx, rst_cnt;

  function automatic int top_bit(logic [7:0] v);
    int r = -1;
    for (int i = 0; i < 8; i++) if (v[i]) r = i;
    return r;
  endfunction

  function automatic logic [7:0] low_vec(logic [7:0] c, int idx);
    int sh = c[1:0] + 1;
    int keep = 8 - (sh + 3);
    logic [7:0] hi = 8'h00;
    for (int b = 7; b > 7 - keep; b--) hi[b] = c[b];
    return hi | 8'((idx & 7) * (1 << sh));
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_lat = 0; m_prev = 0; m_page = 0; m_ctrl = 0; m_mask = 0;
      m_phase = 0; m_idx = 0; rst_cnt = 0;
    end else if (rst_cnt < 2) begin
      rst_cnt++;
    end else begin
      logic [7:0] set_v, clr_v;
      int w;
      set_v = m_prev & ~req;
      clr_v = 0;
      if (cs && rd && !fetch && addr == 0) clr_v = 8'hFF;
      if (cs && fetch) begin
        if (m_phase == 0) begin
          w = top_bit(m_lat & ~m_mask);
          if (w >= 0) begin clr_v[w] = 1'b1; m_idx = w; end
          else m_idx = 0;
        end
        m_phase = (m_phase == 2) ? 0 : m_phase + 1;
      end
      if (cs && wr && !fetch) begin
        if (addr == 0) m_page = wdata;
        if (addr == 1) m_ctrl = wdata;
        if (addr == 2) m_mask = wdata;
      end
      m_lat  = (m_lat & ~clr_v) | set_v;
      m_prev = req;
    end
  end

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // cycle compare, away from the clock edge
  initial begin
    forever begin
      @(negedge clk); #3;
      if (rst_n && !done) begin
        logic       e_oe, e_irq;
        logic [7:0] e_d;
        int t;
        e_irq = !(((m_lat & ~m_mask) != 0) || !cascade_n);
        chk("R5 irq_n", {7'd0, irq_n}, {7'd0, e_irq});
        e_oe = cs && (fetch || (rd && addr <= 1));
        chk("R10 oe", {7'd0, rdata_oe}, {7'd0, e_oe});
        if (e_oe) begin
          if (fetch) begin
            e_d = (m_phase == 0) ? 8'hC0 : (m_phase == 1) ? m_page : low_vec(m_ctrl, m_idx);
            chk("R6 fetch byte", rdata, e_d);
          end else if (addr == 0) begin
            chk("R3 status", rdata, m_lat);
          end else begin
            t = top_bit(m_lat);
            chk("R9 poll", rdata, low_vec(m_ctrl, (t < 0) ? 0 : t));
          end
        end
      end
    end
  end

  task automatic idle_bus();
    cs = 0; rd = 0; wr = 0; fetch = 0; addr = 0; wdata = 0;
  endtask

  task automatic wr_reg(logic [1:0] a, logic [7:0] d, logic sel = 1'b1);
    @(negedge clk); cs = sel; wr = 1; addr = a; wdata = d;
    @(negedge clk); idle_bus();
  endtask

  task automatic rd_reg(logic [1:0] a, output logic [7:0] v, output logic oe);
    @(negedge clk); cs = 1; rd = 1; addr = a;
    #3 v = rdata; oe = rdata_oe;
    @(negedge clk); idle_bus();
  endtask

  task automatic fetch3(output logic [7:0] b0, output logic [7:0] b1, output logic [7:0] b2);
    @(negedge clk); cs = 1; fetch = 1; #3 b0 = rdata;
    @(negedge clk); #3 b1 = rdata;
    @(negedge clk); #3 b2 = rdata;
    @(negedge clk); idle_bus();
  endtask

  task automatic pulse(int i);
    @(negedge clk); req[i] = 1'b0;
    @(negedge clk); req[i] = 1'b1;
  endtask

  initial begin
    logic [7:0] v, b0, b1, b2;
    logic oe;
    rst_n = 0; req = 8'hFF; cascade_n = 1; idle_bus();
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 irq_n in reset", {7'd0, irq_n}, 8'd1);
    chk("R1 oe in reset", {7'd0, rdata_oe}, 8'd0);
    rst_n = 1;
    repeat (5) @(negedge clk);
    rd_reg(0, v, oe); chk("R1 status after reset", v, 8'h00);
    fetch3(b0, b1, b2);
    chk("R1 opcode first", b0, 8'hC0);
    chk("R1 page zero", b1, 8'h00);
    chk("R1 low zero", b2, 8'h00);

    // R2 falling edge latches; steady low does not re-latch
    @(negedge clk); req[3] = 0;
    repeat (2) @(negedge clk); #3;
    chk("R2 irq after edge", {7'd0, irq_n}, 8'd0);
    rd_reg(0, v, oe); chk("R3 status shows line 3", v, 8'h08);
    rd_reg(0, v, oe); chk("R3 status cleared", v, 8'h00);
    @(negedge clk); #3 chk("R2 steady low no latch", {7'd0, irq_n}, 8'd1);
    @(negedge clk); req[3] = 1;

    // R4 mask keeps latch but silences irq
    wr_reg(2, 8'h04);
    pulse(2);
    @(negedge clk); #3 chk("R4 masked irq quiet", {7'd0, irq_n}, 8'd1);
    // R5 cascade is not maskable
    wr_reg(2, 8'hFF);
    @(negedge clk); cascade_n = 0; #3 chk("R5 cascade pulls irq", {7'd0, irq_n}, 8'd0);
    @(negedge clk); cascade_n = 1;
    rd_reg(0, v, oe); chk("R4 masked latch visible", v, 8'h04);

    // R6/R7/R9 branch sequence
    wr_reg(2, 8'h00); wr_reg(0, 8'h12); wr_reg(1, 8'hA5);
    pulse(5); pulse(1);
    rd_reg(1, v, oe); chk("R9 poll spacing 4", v, 8'hB4);
    fetch3(b0, b1, b2);
    chk("R6 opcode", b0, 8'hC0);
    chk("R6 page byte", b1, 8'h12);
    chk("R7 low byte line 5", b2, 8'hB4);
    rd_reg(0, v, oe); chk("R7 only line 5 cleared", v, 8'h02);

    // R7 masked higher line loses
    wr_reg(2, 8'h80);
    pulse(7); pulse(4);
    fetch3(b0, b1, b2);
    chk("R7 masked winner skipped", b2, 8'hB0);
    rd_reg(0, v, oe); chk("R7 masked line stays", v, 8'h80);

    // R8 all four spacings with line 6
    wr_reg(2, 8'h00);
    pulse(6);
    wr_reg(1, 8'hD0); rd_reg(1, v, oe); chk("R8 spacing 2", v, 8'hDC);
    wr_reg(1, 8'hD1); rd_reg(1, v, oe); chk("R8 spacing 4", v, 8'hD8);
    wr_reg(1, 8'hD2); rd_reg(1, v, oe); chk("R8 spacing 8", v, 8'hF0);
    wr_reg(1, 8'hDF); rd_reg(1, v, oe); chk("R8 spacing 16 bits 3:2 ignored", v, 8'hE0);

    // R11 nothing unmasked at fetch
    wr_reg(2, 8'hFF);
    fetch3(b0, b1, b2);
    chk("R11 index zero", b2, 8'h80);
    rd_reg(0, v, oe); chk("R11 latch untouched", v, 8'h40);

    // R10 decode
    wr_reg(0, 8'h77, 1'b0);
    wr_reg(3, 8'h55);
    wr_reg(2, 8'h00);
    fetch3(b0, b1, b2);
    chk("R10 deselected write ignored", b1, 8'h12);
    chk("R10 addr3 write ignored", b2, 8'h80);
    rd_reg(2, v, oe); chk("R10 read addr2 not driven", {7'd0, oe}, 8'd0);
    @(negedge clk); rd = 1; addr = 0; #3 chk("R10 no cs not driven", {7'd0, rdata_oe}, 8'd0);
    @(negedge clk); idle_bus();

    // R3 edge in the clearing cycle survives
    pulse(2);
    @(negedge clk); cs = 1; rd = 1; addr = 0; req[0] = 0;
    #3 chk("R3 read before clear", rdata, 8'h04);
    @(negedge clk); idle_bus(); req[0] = 1;
    rd_reg(0, v, oe); chk("R3 same-cycle edge kept", v, 8'h01);

    // random phase, compared each cycle
    for (int n = 0; n < 3000; n++) begin
      int op;
      @(negedge clk); idle_bus();
      op = $urandom % 10;
      case (op)
        0, 1, 2: req = 8'($urandom);
        3: begin cs = 1; wr = 1; addr = 2; wdata = 8'($urandom); end
        4: begin cs = 1; wr = 1; addr = 2'($urandom); wdata = 8'($urandom); end
        5: begin cs = 1; rd = 1; addr = 2'($urandom); end
        6, 7: begin cs = 1; fetch = 1; end
        8: cascade_n = 1'($urandom);
        default: begin cs = 1'($urandom); rd = 1; wr = 0; addr = 1; end
      endcase
    end
    @(negedge clk); idle_bus();
    repeat (3) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    done = 1;
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule